// File: doc/BRIEF.md
# JTAG TAP Bus Observer

This block watches a JTAG test port without ever driving it. The four port wires (test clock, mode select, serial data into the device, serial data out of the device) are brought into the fast system clock domain through short synchroniser chains. Rising edges of the test clock are detected from the synchronised samples. On each such edge, the block advances its own copy of the 16-state TAP controller, using the mode-select value from that same sample.

Every state update is announced with a one-cycle pulse and the new 4-bit state code. One exception: the first test-clock edge after reset updates the state silently. While the port sits in a shift state, the block collects the data-in and data-out bits into two vectors, with the earliest bit in bit 0. When shifting ends on the move into Exit1, it reports one scan result. That result holds both vectors, the bit count, an IR/DR tag and an overflow flag. Vectors hold up to `MAXBITS` bits. Bits beyond that limit are dropped, and the count stops at the limit.

Typical use is inside a debug or trace subsystem. There, register accesses on a board-level test port are reconstructed for logging or triggering.

Top module: `tapmon_top`

## Requirements
- R1: After a synchronous active-high reset, `state_o` is Run-Test/Idle (code 1), and `state_vld_o`, `scan_vld_o` and `scan_cnt_o` are 0.
- R2: On each test-clock rising edge the tracked state follows the TAP graph with codes Test-Logic-Reset=0, Run-Test/Idle=1, DR Select/Capture/Shift/Exit1/Pause/Exit2/Update=2..8, IR Select/Capture/Shift/Exit1/Pause/Exit2/Update=9..15. The mode-select value taken is the one sampled at that edge.
- R3: Every test-clock rising edge produces exactly one single-cycle `state_vld_o` pulse carrying the new state, except the first edge after reset. That first edge advances the state but gives no pulse.
- R4: On each edge whose new state is Shift-DR (4) or Shift-IR (11), the data-in and data-out values sampled at that edge are stored. The first stored bit is bit 0 and each later one takes the next higher position.
- R5: On an edge from a shift state to Exit1, `scan_vld_o` pulses once in the same cycle as the `state_vld_o` pulse for Exit1. `scan_ir_o` is 1 for the IR branch and 0 for DR, and the vectors and bit count are presented. Moving from Capture straight to Exit1 reports no scan.
- R6: Bits beyond `MAXBITS` in one scan are dropped, `scan_cnt_o` stops at `MAXBITS`, and `scan_ovf_o` is 1 with that scan's result. Otherwise `scan_ovf_o` is 0.
- R7: After a result is reported, the next scan starts empty. A scan resumed through Pause and Exit2 is reported as a new result counting from bit 0.
- R8: Changes of mode-select or data pins while the test clock has no rising edge change neither the state nor the pulses.
- R9: A reset in the middle of a scan discards the partial vectors, returns the state to Run-Test/Idle and re-arms the first-edge suppression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the test clock |
| rst_i | input | 1 | Synchronous active-high reset |
| probe_clk_i | input | 1 | Observed test clock |
| probe_mode_i | input | 1 | Observed mode-select line |
| probe_din_i | input | 1 | Observed serial data into the device |
| probe_dout_i | input | 1 | Observed serial data out of the device |
| state_o | output | 4 | Tracked TAP state code |
| state_vld_o | output | 1 | One-cycle pulse on each reported state update |
| scan_vld_o | output | 1 | One-cycle pulse on each completed scan |
| scan_ir_o | output | 1 | 1 when the completed scan was on the IR branch |
| scan_din_o | output | MAXBITS | Data-in vector of the completed scan, first bit in bit 0 |
| scan_dout_o | output | MAXBITS | Data-out vector of the completed scan, first bit in bit 0 |
| scan_cnt_o | output | clog2(MAXBITS+1) | Bit count of the completed scan, saturating |
| scan_ovf_o | output | 1 | Completed scan exceeded MAXBITS |

## Verification
The state-update pulse and the scan-completion pulse coincide on every edge that leaves a shift state for Exit1. The bench provokes this with DR, IR, paused and over-long scans. Its monitor pops one expected state item and one expected scan item at that point. Whenever the scan queue is popped, it also demands that the state pulse is present in the same sampled cycle. The overflow flag is judged on that same coincident cycle, when a scan longer than the vector width ends.

// File: rtl/tapmon_pkg.sv
package tapmon_pkg;

    typedef enum logic [3:0] {
        TS_RESET      = 4'd0,
        TS_IDLE       = 4'd1,
        TS_DR_SELECT  = 4'd2,
        TS_DR_CAPTURE = 4'd3,
        TS_DR_SHIFT   = 4'd4,
        TS_DR_EXIT1   = 4'd5,
        TS_DR_PAUSE   = 4'd6,
        TS_DR_EXIT2   = 4'd7,
        TS_DR_UPDATE  = 4'd8,
        TS_IR_SELECT  = 4'd9,
        TS_IR_CAPTURE = 4'd10,
        TS_IR_SHIFT   = 4'd11,
        TS_IR_EXIT1   = 4'd12,
        TS_IR_PAUSE   = 4'd13,
        TS_IR_EXIT2   = 4'd14,
        TS_IR_UPDATE  = 4'd15
    } tap_state_e;

    // Positions of the observed wires in the synchroniser bundle
    localparam int NPINS    = 4;
    localparam int PIN_CK   = 0;
    localparam int PIN_MODE = 1;
    localparam int PIN_DIN  = 2;
    localparam int PIN_DOUT = 3;

    function automatic tap_state_e tap_step(tap_state_e s, logic m);
        tap_state_e n;
        unique case (s)
            TS_RESET:      n = m ? TS_RESET     : TS_IDLE;
            TS_IDLE:       n = m ? TS_DR_SELECT : TS_IDLE;
            TS_DR_SELECT:  n = m ? TS_IR_SELECT : TS_DR_CAPTURE;
            TS_DR_CAPTURE: n = m ? TS_DR_EXIT1  : TS_DR_SHIFT;
            TS_DR_SHIFT:   n = m ? TS_DR_EXIT1  : TS_DR_SHIFT;
            TS_DR_EXIT1:   n = m ? TS_DR_UPDATE : TS_DR_PAUSE;
            TS_DR_PAUSE:   n = m ? TS_DR_EXIT2  : TS_DR_PAUSE;
            TS_DR_EXIT2:   n = m ? TS_DR_UPDATE : TS_DR_SHIFT;
            TS_DR_UPDATE:  n = m ? TS_DR_SELECT : TS_IDLE;
            TS_IR_SELECT:  n = m ? TS_RESET     : TS_IR_CAPTURE;
            TS_IR_CAPTURE: n = m ? TS_IR_EXIT1  : TS_IR_SHIFT;
            TS_IR_SHIFT:   n = m ? TS_IR_EXIT1  : TS_IR_SHIFT;
            TS_IR_EXIT1:   n = m ? TS_IR_UPDATE : TS_IR_PAUSE;
            TS_IR_PAUSE:   n = m ? TS_IR_EXIT2  : TS_IR_PAUSE;
            TS_IR_EXIT2:   n = m ? TS_IR_UPDATE : TS_IR_SHIFT;
            default:       n = m ? TS_DR_SELECT : TS_IDLE;
        endcase
        return n;
    endfunction

    function automatic logic is_shift(tap_state_e s);
        return (s == TS_DR_SHIFT) || (s == TS_IR_SHIFT);
    endfunction

    function automatic logic is_exit1(tap_state_e s);
        return (s == TS_DR_EXIT1) || (s == TS_IR_EXIT1);
    endfunction

    function automatic logic is_ir_branch(tap_state_e s);
        return s >= TS_IR_SELECT;
    endfunction

endpackage

// File: rtl/tapmon_sync.sv
// Brings the observed port wires into the system clock domain and flags
// test-clock rising edges from the synchronised samples.
module tapmon_sync #(
    parameter int STAGES = 2,
    parameter int NPINS  = 4,
    parameter int CK_IDX = 0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NPINS-1:0] pins_i,
    output logic [NPINS-1:0] synced_o,
    output logic             rise_o
);

    for (genvar g = 0; g < NPINS; g++) begin : g_lane
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], pins_i[g]};
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) chain_q <= '0;
            else       chain_q <= chain_d;
        end

        assign synced_o[g] = chain_q[STAGES-1];
    end

    typedef struct packed {
        logic ck_prev;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d         = edge_q;
        edge_d.ck_prev = synced_o[CK_IDX];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) edge_q <= '0;
        else       edge_q <= edge_d;
    end

    assign rise_o = synced_o[CK_IDX] & ~edge_q.ck_prev;

endmodule

// File: rtl/tapmon_track.sv
// TAP state follower with first-edge suppression of the update pulse.
module tapmon_track
    import tapmon_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       rise_i,
    input  logic       mode_i,
    output tap_state_e cur_o,
    output tap_state_e nxt_o,
    output logic       vld_o
);

    typedef struct packed {
        tap_state_e st;
        logic       armed;
        logic       vld;
    } track_t;

    localparam track_t TRACK_RST = '{st: TS_IDLE, armed: 1'b1, vld: 1'b0};

    track_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        trk_d.vld = 1'b0;
        if (rise_i) begin
            trk_d.st    = tap_step(trk_q.st, mode_i);
            trk_d.vld   = ~trk_q.armed;
            trk_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) trk_q <= TRACK_RST;
        else       trk_q <= trk_d;
    end

    assign cur_o = trk_q.st;
    assign nxt_o = trk_d.st;
    assign vld_o = trk_q.vld;

endmodule

// File: rtl/tapmon_collect.sv
// Gathers shifted bits and presents a finished scan on the Shift->Exit1 edge.
module tapmon_collect
    import tapmon_pkg::*;
#(
    parameter int MAXBITS = 64,
    localparam int CW = $clog2(MAXBITS + 1),
    localparam int IW = (MAXBITS > 1) ? $clog2(MAXBITS) : 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               rise_i,
    input  tap_state_e         cur_i,
    input  tap_state_e         nxt_i,
    input  logic               din_i,
    input  logic               dout_i,
    output logic               done_o,
    output logic               ir_o,
    output logic [MAXBITS-1:0] din_vec_o,
    output logic [MAXBITS-1:0] dout_vec_o,
    output logic [CW-1:0]      cnt_o,
    output logic               ovf_o
);

    typedef struct packed {
        logic [MAXBITS-1:0] acc_in;
        logic [MAXBITS-1:0] acc_out;
        logic [CW-1:0]      acc_cnt;
        logic               acc_ovf;
        logic [MAXBITS-1:0] res_in;
        logic [MAXBITS-1:0] res_out;
        logic [CW-1:0]      res_cnt;
        logic               res_ovf;
        logic               res_ir;
        logic               done;
    } coll_t;

    coll_t col_d, col_q;
    logic  has_room;
    logic  finishing;

    assign has_room  = col_q.acc_cnt < CW'(MAXBITS);
    assign finishing = is_shift(cur_i) && is_exit1(nxt_i);

    always_comb begin
        col_d      = col_q;
        col_d.done = 1'b0;
        if (rise_i) begin
            if (is_shift(nxt_i)) begin
                if (has_room) begin
                    col_d.acc_in[col_q.acc_cnt[IW-1:0]]  = din_i;
                    col_d.acc_out[col_q.acc_cnt[IW-1:0]] = dout_i;
                    col_d.acc_cnt = col_q.acc_cnt + CW'(1);
                end else begin
                    col_d.acc_ovf = 1'b1;
                end
            end
            if (finishing) begin
                col_d.res_in  = col_q.acc_in;
                col_d.res_out = col_q.acc_out;
                col_d.res_cnt = col_q.acc_cnt;
                col_d.res_ovf = col_q.acc_ovf;
                col_d.res_ir  = is_ir_branch(nxt_i);
                col_d.done    = 1'b1;
                col_d.acc_in  = '0;
                col_d.acc_out = '0;
                col_d.acc_cnt = '0;
                col_d.acc_ovf = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) col_q <= '0;
        else       col_q <= col_d;
    end

    assign done_o     = col_q.done;
    assign ir_o       = col_q.res_ir;
    assign din_vec_o  = col_q.res_in;
    assign dout_vec_o = col_q.res_out;
    assign cnt_o      = col_q.res_cnt;
    assign ovf_o      = col_q.res_ovf;

endmodule

// File: rtl/tapmon_top.sv
// Passive observer of a JTAG test port.
module tapmon_top
    import tapmon_pkg::*;
#(
    parameter int MAXBITS = 64
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         probe_clk_i,
    input  logic                         probe_mode_i,
    input  logic                         probe_din_i,
    input  logic                         probe_dout_i,
    output logic [3:0]                   state_o,
    output logic                         state_vld_o,
    output logic                         scan_vld_o,
    output logic                         scan_ir_o,
    output logic [MAXBITS-1:0]           scan_din_o,
    output logic [MAXBITS-1:0]           scan_dout_o,
    output logic [$clog2(MAXBITS+1)-1:0] scan_cnt_o,
    output logic                         scan_ovf_o
);

    logic [NPINS-1:0] raw_pins;
    logic [NPINS-1:0] synced;
    logic             rise;
    tap_state_e       cur_st, nxt_st;

    always_comb begin
        raw_pins           = '0;
        raw_pins[PIN_CK]   = probe_clk_i;
        raw_pins[PIN_MODE] = probe_mode_i;
        raw_pins[PIN_DIN]  = probe_din_i;
        raw_pins[PIN_DOUT] = probe_dout_i;
    end

    tapmon_sync #(
        .STAGES (2),
        .NPINS  (NPINS),
        .CK_IDX (PIN_CK)
    ) sync_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .pins_i   (raw_pins),
        .synced_o (synced),
        .rise_o   (rise)
    );

    tapmon_track track_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .rise_i (rise),
        .mode_i (synced[PIN_MODE]),
        .cur_o  (cur_st),
        .nxt_o  (nxt_st),
        .vld_o  (state_vld_o)
    );

    tapmon_collect #(
        .MAXBITS (MAXBITS)
    ) collect_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rise_i     (rise),
        .cur_i      (cur_st),
        .nxt_i      (nxt_st),
        .din_i      (synced[PIN_DIN]),
        .dout_i     (synced[PIN_DOUT]),
        .done_o     (scan_vld_o),
        .ir_o       (scan_ir_o),
        .din_vec_o  (scan_din_o),
        .dout_vec_o (scan_dout_o),
        .cnt_o      (scan_cnt_o),
        .ovf_o      (scan_ovf_o)
    );

    assign state_o = cur_st;

endmodule

// File: rtl/tapmon_chk.sv
module tapmon_chk
    import tapmon_pkg::*;
#(
    parameter int MAXBITS = 64
) (
    input logic                         clk_i,
    input logic                         rst_i,
    input logic [3:0]                   state_o,
    input logic                         state_vld_o,
    input logic                         scan_vld_o,
    input logic                         scan_ir_o,
    input logic [$clog2(MAXBITS+1)-1:0] scan_cnt_o,
    input logic                         scan_ovf_o
);

    AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (state_o == TS_IDLE && !state_vld_o && !scan_vld_o)); // R1

    AST_DR_SHIFT_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_vld_o && state_o == TS_DR_SHIFT) |->
            ($past(state_o) inside {TS_DR_CAPTURE, TS_DR_SHIFT, TS_DR_EXIT2})); // R2

    AST_RESET_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_vld_o && state_o == TS_RESET) |->
            ($past(state_o) inside {TS_RESET, TS_IR_SELECT})); // R2

    AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        state_vld_o |=> !state_vld_o); // R3

    AST_DONE_AT_EXIT: assert property (@(posedge clk_i) disable iff (rst_i)
        scan_vld_o |-> (state_vld_o && (state_o == TS_DR_EXIT1 || state_o == TS_IR_EXIT1)
                        && ($past(state_o) == TS_DR_SHIFT || $past(state_o) == TS_IR_SHIFT))); // R5

    AST_BRANCH_TAG: assert property (@(posedge clk_i) disable iff (rst_i)
        scan_vld_o |-> (scan_ir_o == (state_o == TS_IR_EXIT1))); // R5

    AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
        scan_vld_o |-> (scan_cnt_o <= MAXBITS)); // R6

    AST_OVF_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
        (scan_vld_o && scan_ovf_o) |-> (scan_cnt_o == MAXBITS)); // R6

endmodule

bind tapmon_top tapmon_chk #(.MAXBITS(MAXBITS)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .state_o     (state_o),
    .state_vld_o (state_vld_o),
    .scan_vld_o  (scan_vld_o),
    .scan_ir_o   (scan_ir_o),
    .scan_cnt_o  (scan_cnt_o),
    .scan_ovf_o  (scan_ovf_o)
);

// File: tb/tapmon_top_tb_top.sv
`timescale 1ns/1ps
module tapmon_top_tb_top;

    localparam int MB = 16;
    localparam int CW = $clog2(MB + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic p_ck = 1'b0, p_mode = 1'b0, p_din = 1'b0, p_dout = 1'b0;

    logic [3:0]    state_o;
    logic          state_vld_o, scan_vld_o, scan_ir_o, scan_ovf_o;
    logic [MB-1:0] scan_din_o, scan_dout_o;
    logic [CW-1:0] scan_cnt_o;

    always #4 clk = ~clk;

    tapmon_top #(.MAXBITS(MB)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .probe_clk_i  (p_ck),
        .probe_mode_i (p_mode),
        .probe_din_i  (p_din),
        .probe_dout_i (p_dout),
        .state_o      (state_o),
        .state_vld_o  (state_vld_o),
        .scan_vld_o   (scan_vld_o),
        .scan_ir_o    (scan_ir_o),
        .scan_din_o   (scan_din_o),
        .scan_dout_o  (scan_dout_o),
        .scan_cnt_o   (scan_cnt_o),
        .scan_ovf_o   (scan_ovf_o)
    );

    typedef struct packed {
        logic          ir;
        logic [MB-1:0] din;
        logic [MB-1:0] dout;
        logic [CW-1:0] cnt;
        logic          ovf;
    } scan_item_t;

    logic [3:0]  exp_st_q[$];
    scan_item_t  exp_scan_q[$];

    int    n_chk = 0, n_fail = 0, n_pulse = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // Bench-side model of the port
    int            m_st = 1;
    bit            m_armed = 1;
    logic [MB-1:0] m_in = '0, m_out = '0;
    int            m_cnt = 0;
    bit            m_ovf = 0;

    function automatic int step_of(int s, bit m);
        case (s)
            0:  return m ? 0 : 1;
            1:  return m ? 2 : 1;
            2:  return m ? 9 : 3;
            3:  return m ? 5 : 4;
            4:  return m ? 5 : 4;
            5:  return m ? 8 : 6;
            6:  return m ? 7 : 6;
            7:  return m ? 8 : 4;
            8:  return m ? 2 : 1;
            9:  return m ? 0 : 10;
            10: return m ? 12 : 11;
            11: return m ? 12 : 11;
            12: return m ? 15 : 13;
            13: return m ? 14 : 13;
            14: return m ? 15 : 11;
            default: return m ? 2 : 1;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one test-clock period, updating the model and pushing expectations
    task automatic tick(input bit m, input bit di = 0, input bit dq = 0);
        int nx;
        scan_item_t it;
        @(negedge clk);
        p_mode = m; p_din = di; p_dout = dq;
        repeat (3) @(negedge clk);
        nx = step_of(m_st, m);
        if (!m_armed) exp_st_q.push_back(4'(nx));
        m_armed = 0;
        if (nx == 4 || nx == 11) begin
            if (m_cnt < MB) begin
                m_in[m_cnt] = di; m_out[m_cnt] = dq; m_cnt++;
            end else m_ovf = 1;
        end
        if ((m_st == 4 || m_st == 11) && (nx == 5 || nx == 12)) begin
            it.ir = (nx == 12); it.din = m_in; it.dout = m_out;
            it.cnt = CW'(m_cnt); it.ovf = m_ovf;
            exp_scan_q.push_back(it);
            m_in = '0; m_out = '0; m_cnt = 0; m_ovf = 0;
        end
        m_st = nx;
        p_ck = 1'b1;
        repeat (4) @(negedge clk);
        p_ck = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_st = 1; m_armed = 1; m_in = '0; m_out = '0; m_cnt = 0; m_ovf = 0;
    endtask

    // n bits shifted (tms=0), then the exit edge; starts from Capture
    task automatic shift_bits(input int n, input logic [31:0] vi, input logic [31:0] vo);
        for (int i = 0; i < n; i++) tick(0, vi[i % 32], vo[i % 32]);
        tick(1, 1, 1);
    endtask

    task automatic to_dr_capture(); tick(1); tick(0); endtask
    task automatic to_ir_capture(); tick(1); tick(1); tick(0); endtask
    task automatic update_to_idle(); tick(1); tick(0); endtask

    // Monitor: pops expected items as the design reports them
    always @(negedge clk) begin
        if (!rst) begin
            if (state_vld_o) begin
                n_pulse++;
                if (exp_st_q.size() == 0)
                    check(cur_req, "unexpected state pulse", 64'(state_o), 64'hFFFF);
                else
                    check(cur_req, "state code", 64'(state_o), 64'(exp_st_q.pop_front()));
            end
            if (scan_vld_o) begin
                scan_item_t e;
                check("R5", "scan with state pulse same cycle", 64'(state_vld_o), 64'd1);
                if (exp_scan_q.size() == 0)
                    check(cur_req, "unexpected scan", 64'(scan_cnt_o), 64'hFFFF);
                else begin
                    e = exp_scan_q.pop_front();
                    check("R5", "scan ir tag", 64'(scan_ir_o), 64'(e.ir));
                    check("R4", "scan din vector", 64'(scan_din_o), 64'(e.din));
                    check("R4", "scan dout vector", 64'(scan_dout_o), 64'(e.dout));
                    check(cur_req, "scan count", 64'(scan_cnt_o), 64'(e.cnt));
                    check("R6", "scan overflow", 64'(scan_ovf_o), 64'(e.ovf));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R-all: actual expired expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int pc;
        do_reset();
        cur_req = "R1";
        check("R1", "reset state", 64'(state_o), 64'd1);
        check("R1", "reset state pulse", 64'(state_vld_o), 64'd0);
        check("R1", "reset scan pulse", 64'(scan_vld_o), 64'd0);
        check("R1", "reset count", 64'(scan_cnt_o), 64'd0);

        cur_req = "R3";
        pc = n_pulse;
        tick(0);
        repeat (6) @(negedge clk);
        check("R3", "first edge silent", 64'(n_pulse - pc), 64'd0);
        check("R3", "first edge state", 64'(state_o), 64'd1);
        tick(1); tick(0);                      // select -> capture
        repeat (6) @(negedge clk);
        check("R3", "pulses after first", 64'(n_pulse - pc), 64'd2);

        cur_req = "R4";                        // DR scan of 8 bits
        shift_bits(8, 32'h0000_00B5, 32'h0000_003C);
        update_to_idle();

        cur_req = "R5";                        // IR scan of 5 bits
        to_ir_capture();
        shift_bits(5, 32'h0000_0013, 32'h0000_0009);
        update_to_idle();

        cur_req = "R5";                        // Capture straight to Exit1: no scan
        to_dr_capture();
        tick(1);
        update_to_idle();

        cur_req = "R7";                        // paused and resumed scan
        to_dr_capture();
        shift_bits(3, 32'h5, 32'h2);
        tick(0); tick(0); tick(1);             // pause, pause, exit2
        tick(0, 1, 0); tick(0, 1, 1);          // back to shift, two bits
        tick(1);                               // exit1
        update_to_idle();

        cur_req = "R6";                        // over-long scan
        to_dr_capture();
        shift_bits(MB + 5, 32'hA5C3_96E1, 32'h1234_5678);
        update_to_idle();

        cur_req = "R2";                        // through Test-Logic-Reset
        tick(1); tick(1); tick(1); tick(1); tick(0);

        cur_req = "R8";
        tick(1);                               // in DR select, mode matters
        repeat (6) @(negedge clk);
        pc = n_pulse;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            p_mode = i[0]; p_din = i[1]; p_dout = i[2];
        end
        repeat (6) @(negedge clk);
        check("R8", "no pulse without edge", 64'(n_pulse - pc), 64'd0);
        check("R8", "state held", 64'(state_o), 64'd2);
        tick(1); tick(1); tick(0);             // back to idle via reset

        cur_req = "R9";
        to_dr_capture();
        for (int i = 0; i < 4; i++) tick(0, 1, 1);
        repeat (4) @(negedge clk);
        do_reset();
        check("R9", "state after mid-scan reset", 64'(state_o), 64'd1);
        check("R9", "scan pulse after reset", 64'(scan_vld_o), 64'd0);
        pc = n_pulse;
        tick(0);
        repeat (6) @(negedge clk);
        check("R9", "first edge re-armed", 64'(n_pulse - pc), 64'd0);
        to_dr_capture();
        shift_bits(2, 32'h1, 32'h2);
        update_to_idle();

        repeat (10) @(negedge clk);
        check("R5", "pending scans", 64'(exp_scan_q.size()), 64'd0);
        check("R3", "pending states", 64'(exp_st_q.size()), 64'd0);
        check("R2", "final state", 64'(state_o), 64'(m_st));
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule